// File: doc/BRIEF.md
# Eight-bit compare-match timer

This block is an 8-bit up-counter that runs against two compare registers, named A and B. One output pin is driven from the match events of the two channels. When the counter holds a channel's compare value during a cycle in which it advances, that channel matches. The match then applies a 2-bit action to the pin:

- keep the current level,
- drive it low,
- drive it high,
- or invert it.

The block also keeps three sticky event flags: match A, match B and counter wrap. A CPU clears them with a two-step handshake. The same flags drive level-sensitive interrupt request pins.

A CPU reaches the block through a small synchronous register bus. The bus has a 2-bit address, write data, a write strobe, a read strobe and combinational read data. The counter, both compare values and a control/status byte each have their own address. A separate enable input decides in which cycles the counter advances.

Top module: `cmt_top`

## Requirements
- R1: After reset the counter reads 0. In every cycle with `cntEn` high and no counter write, the counter advances by one, and 0xFF is followed by 0x00.
- R2: A bus write to address 0 loads the counter at that clock edge and takes priority over counting. In that cycle no match event and no wrap event is produced, even if the old count equals a compare value.
- R3: Compare registers sit at address 1 (A) and address 2 (B), and both reset to 0xFF. A channel matches in a cycle where `cntEn` is high, the counter is not written, and the count equals that channel's compare value. From the next edge its flag reads 1: bit 6 of address 3 for A, bit 7 for B.
- R4: When the counter advances from 0xFF to 0x00, the wrap flag (bit 5 of address 3) reads 1 from that edge on.
- R5: A flag is cleared only by a write to address 3 with that bit at 0, after a read strobe on address 3 that saw the flag at 1. Writing 1 never sets a flag, and writing 0 without the earlier read leaves the flag set.
- R6: If a flag's event fires again after the arming read but before the clearing write, that write leaves the flag set.
- R7: Bit 4 of address 3 always reads 1, and writes to it have no effect.
- R8: Address 3 bits [3:2] hold the B action and bits [1:0] hold the A action. Each uses the code 00 keep, 01 low, 10 high, 11 invert. On the edge after a match, `timerOut` takes the new level.
- R9: When A and B match in the same cycle with different actions, B wins. The exception is invert combined with low or high: there the low or high action wins. Invert with invert inverts once.
- R10: While all four action bits are 0, `timerOut` is forced to 0 from the next edge on.
- R11: Reset clears all flags and all action bits, and `timerOut` is 0. Address 3 then reads 0x10.
- R12: `irqMatchA`, `irqMatchB` and `irqWrap` always equal flag bits 6, 7 and 5 of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (arms flag clearing) |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| cntEn | input | 1 | Count enable |
| timerOut | output | 1 | Timer output pin |
| irqMatchA | output | 1 | Match A flag / interrupt request |
| irqMatchB | output | 1 | Match B flag / interrupt request |
| irqWrap | output | 1 | Counter wrap flag / interrupt request |

## Verification
The bench builds the block with its default 8-bit data width and 2-bit address. At that width a full wrap takes 256 enabled cycles, so random runs of a few thousand cycles cross 0xFF many times. They also hit the compare values often enough to collide with counter loads, arming reads and clearing writes. Directed sequences set A and B to the same value so that every pairing of actions in the priority rule is exercised. They also re-fire a flag between its arming read and its clearing write.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int NUM_CMP = 2;
  localparam int NUM_FLG = 3;

  localparam logic [AW-1:0] ADDR_CNT  = AW'(0);
  localparam logic [AW-1:0] ADDR_CMPA = AW'(1);
  localparam logic [AW-1:0] ADDR_CMPB = AW'(2);
  localparam logic [AW-1:0] ADDR_CTRL = AW'(3);

  localparam int FLAG_B_BIT   = 7;
  localparam int FLAG_A_BIT   = 6;
  localparam int FLAG_WRAP_BIT = 5;
  localparam int RSV_BIT      = 4;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'b00,
    OUT_LOW    = 2'b01,
    OUT_HIGH   = 2'b10,
    OUT_TOGGLE = 2'b11
  } outAct_e;

  // control -> datapath strobes
  typedef struct packed {
    logic          ldCnt;
    logic          ldCmpA;
    logic          ldCmpB;
    logic [DW-1:0] data;
    outAct_e       actA;
    outAct_e       actB;
  } dpCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic hitA;
    logic hitB;
    logic wrap;
  } dpEvt_t;

  // flag index 0 = match A, 1 = match B, 2 = wrap
  function automatic int flagPos(input int idx);
    case (idx)
      0:       return FLAG_A_BIT;
      1:       return FLAG_B_BIT;
      default: return FLAG_WRAP_BIT;
    endcase
  endfunction

  // B wins, except that a fixed level beats an inversion
  function automatic outAct_e mergeAct(input outAct_e a, input outAct_e b);
    if (b == OUT_KEEP) return a;
    if (a == OUT_KEEP) return b;
    if (b == OUT_TOGGLE && a != OUT_TOGGLE) return a;
    return b;
  endfunction
endpackage

// File: rtl/cmt_flag.sv
`timescale 1ns/1ps
module cmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic setEvt,
  input  logic readSeen,
  input  logic ctrlWr,
  input  logic wrBit,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (setEvt)                        flag <= 1'b1;
      else if (ctrlWr && armed && !wrBit) flag <= 1'b0;

      if (setEvt)                 armed <= 1'b0;
      else if (readSeen && flag)  armed <= 1'b1;
      else if (ctrlWr)            armed <= 1'b0;
    end
  end
endmodule

// File: rtl/cmt_ctrl.sv
`timescale 1ns/1ps
module cmt_ctrl
  import cmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      busAddr,
  input  logic [DW-1:0]      busWdata,
  input  logic               busWr,
  input  logic               busRd,
  input  dpEvt_t             evt,
  input  logic [DW-1:0]      cntVal,
  input  logic [DW-1:0]      cmpAVal,
  input  logic [DW-1:0]      cmpBVal,
  output dpCmd_t             cmd,
  output logic [DW-1:0]      busRdata,
  output logic [NUM_FLG-1:0] flags
);
  logic [3:0]         selReg;
  logic               ctrlWr;
  logic               ctrlRd;
  logic [NUM_FLG-1:0] evtVec;
  logic [DW-1:0]      statusByte;

  assign ctrlWr = busWr && (busAddr == ADDR_CTRL);
  assign ctrlRd = busRd && (busAddr == ADDR_CTRL);
  assign evtVec = {evt.wrap, evt.hitB, evt.hitA};

  always_ff @(posedge clk) begin
    if (!rst_n)      selReg <= 4'h0;
    else if (ctrlWr) selReg <= busWdata[3:0];
  end

  for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
    localparam int P = flagPos(i);
    cmt_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .setEvt  (evtVec[i]),
      .readSeen(ctrlRd),
      .ctrlWr  (ctrlWr),
      .wrBit   (busWdata[P]),
      .flag    (flags[i])
    );
  end

  always_comb begin
    statusByte          = '0;
    statusByte[3:0]     = selReg;
    statusByte[RSV_BIT] = 1'b1;
    for (int i = 0; i < NUM_FLG; i++) statusByte[flagPos(i)] = flags[i];
  end

  always_comb begin
    case (busAddr)
      ADDR_CNT:  busRdata = cntVal;
      ADDR_CMPA: busRdata = cmpAVal;
      ADDR_CMPB: busRdata = cmpBVal;
      default:   busRdata = statusByte;
    endcase
  end

  always_comb begin
    cmd.ldCnt  = busWr && (busAddr == ADDR_CNT);
    cmd.ldCmpA = busWr && (busAddr == ADDR_CMPA);
    cmd.ldCmpB = busWr && (busAddr == ADDR_CMPB);
    cmd.data   = busWdata;
    cmd.actA   = outAct_e'(selReg[1:0]);
    cmd.actB   = outAct_e'(selReg[3:2]);
  end
endmodule

// File: rtl/cmt_dpath.sv
`timescale 1ns/1ps
module cmt_dpath
  import cmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cntEn,
  input  dpCmd_t        cmd,
  output dpEvt_t        evt,
  output logic [DW-1:0] cntVal,
  output logic [DW-1:0] cmpAVal,
  output logic [DW-1:0] cmpBVal,
  output logic          timerOut
);
  logic [DW-1:0]      cmpReg [NUM_CMP];
  logic [NUM_CMP-1:0] ldCmp;
  logic [NUM_CMP-1:0] hit;
  logic               step;
  logic               outEn;
  outAct_e            effA, effB, finalAct;

  assign step  = cntEn && !cmd.ldCnt;
  assign ldCmp = {cmd.ldCmpB, cmd.ldCmpA};

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)        cmpReg[c] <= '1;
      else if (ldCmp[c]) cmpReg[c] <= cmd.data;
    end
    assign hit[c] = step && (cntVal == cmpReg[c]);
  end

  assign cmpAVal = cmpReg[0];
  assign cmpBVal = cmpReg[1];

  always_ff @(posedge clk) begin
    if (!rst_n)         cntVal <= '0;
    else if (cmd.ldCnt) cntVal <= cmd.data;
    else if (cntEn)     cntVal <= cntVal + 1'b1;
  end

  assign evt.hitA = hit[0];
  assign evt.hitB = hit[1];
  assign evt.wrap = step && (cntVal == {DW{1'b1}});

  assign outEn    = (cmd.actA != OUT_KEEP) || (cmd.actB != OUT_KEEP);
  assign effA     = hit[0] ? cmd.actA : OUT_KEEP;
  assign effB     = hit[1] ? cmd.actB : OUT_KEEP;
  assign finalAct = mergeAct(effA, effB);

  always_ff @(posedge clk) begin
    if (!rst_n || !outEn) timerOut <= 1'b0;
    else begin
      case (finalAct)
        OUT_LOW:    timerOut <= 1'b0;
        OUT_HIGH:   timerOut <= 1'b1;
        OUT_TOGGLE: timerOut <= ~timerOut;
        default:    timerOut <= timerOut;
      endcase
    end
  end
endmodule

// File: rtl/cmt_top.sv
`timescale 1ns/1ps
module cmt_top
  import cmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic          busWr,
  input  logic          busRd,
  output logic [DW-1:0] busRdata,
  input  logic          cntEn,
  output logic          timerOut,
  output logic          irqMatchA,
  output logic          irqMatchB,
  output logic          irqWrap
);
  dpCmd_t             cmd;
  dpEvt_t             evt;
  logic [DW-1:0]      cntVal, cmpAVal, cmpBVal;
  logic [NUM_FLG-1:0] flags;
  logic [3:0]         selCode;

  cmt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .evt(evt), .cntVal(cntVal), .cmpAVal(cmpAVal), .cmpBVal(cmpBVal),
    .cmd(cmd), .busRdata(busRdata), .flags(flags)
  );

  cmt_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .cmd(cmd), .evt(evt),
    .cntVal(cntVal), .cmpAVal(cmpAVal), .cmpBVal(cmpBVal), .timerOut(timerOut)
  );

  assign irqMatchA = flags[0];
  assign irqMatchB = flags[1];
  assign irqWrap   = flags[2];
  assign selCode   = {cmd.actB, cmd.actA};
endmodule

// File: rtl/cmt_checker.sv
`timescale 1ns/1ps
module cmt_checker
  import cmt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busWdata,
  input logic          busWr,
  input logic [DW-1:0] busRdata,
  input logic          cntEn,
  input logic          cntLoad,
  input logic [DW-1:0] cntVal,
  input logic          hitA,
  input logic          hitB,
  input logic          wrap,
  input logic [3:0]    selCode,
  input logic          timerOut,
  input logic          irqMatchA,
  input logic          irqWrap
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEn && !cntLoad) |=> cntVal == DW'($past(cntVal) + 1'b1));

  p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cntLoad |-> !(hitA || hitB || wrap));

  p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hitA |=> irqMatchA);

  p_rise_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqMatchA) |-> $past(hitA));

  p_wrap_from_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqWrap) |-> $past(cntVal) == {DW{1'b1}});

  p_clear_by_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqMatchA) |-> $past(busWr && busAddr == ADDR_CTRL && !busWdata[FLAG_A_BIT]));

  p_rsv_reads_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_CTRL) |-> busRdata[RSV_BIT]);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (selCode == 4'h0) |=> !timerOut);
endmodule

bind cmt_top cmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
  .busWr(busWr), .busRdata(busRdata), .cntEn(cntEn), .cntLoad(cmd.ldCnt),
  .cntVal(cntVal), .hitA(evt.hitA), .hitB(evt.hitB), .wrap(evt.wrap),
  .selCode(selCode), .timerOut(timerOut), .irqMatchA(irqMatchA), .irqWrap(irqWrap)
);

// File: tb/sim_cmt_top.sv
`timescale 1ns/1ps
module sim_cmt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic       cntEn = 1'b0;
  logic [7:0] busRdata;
  logic       timerOut, irqMatchA, irqMatchB, irqWrap;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cmt_top u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .cntEn(cntEn),
    .timerOut(timerOut), .irqMatchA(irqMatchA), .irqMatchB(irqMatchB), .irqWrap(irqWrap)
  );

  // ---------------- reference model ----------------
  int   mCnt, mCmpA, mCmpB, mSel;
  bit   mFlag [3];   // 0 = A, 1 = B, 2 = wrap
  bit   mArm  [3];
  bit   mOut;

  function automatic int expRead(input int a);
    case (a)
      0: return mCnt;
      1: return mCmpA;
      2: return mCmpB;
      default: return (mFlag[1] << 7) | (mFlag[0] << 6) | (mFlag[2] << 5) | 16 | mSel;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = 0; mCmpA = 255; mCmpB = 255; mSel = 0; mOut = 0;
      for (int i = 0; i < 3; i++) begin mFlag[i] = 0; mArm[i] = 0; end
    end else begin
      bit wrC, adv, wrS, rdS;
      bit ev [3];
      int wd, a, b, act;
      int bitIdx [3];
      bitIdx = '{6, 7, 5};
      wd  = busWdata;
      wrC = busWr && busAddr == 0;
      wrS = busWr && busAddr == 3;
      rdS = busRd && busAddr == 3;
      adv = cntEn && !wrC;
      ev[0] = adv && mCnt == mCmpA;
      ev[1] = adv && mCnt == mCmpB;
      ev[2] = adv && mCnt == 255;
      a = ev[0] ? (mSel & 3) : 0;
      b = ev[1] ? (mSel >> 2) : 0;
      if (b == 0) act = a;
      else if (a == 0) act = b;
      else if (b == 3 && a != 3) act = a;
      else act = b;
      if (mSel == 0) mOut = 0;
      else if (act == 1) mOut = 0;
      else if (act == 2) mOut = 1;
      else if (act == 3) mOut = !mOut;
      for (int i = 0; i < 3; i++) begin
        bit oldF;
        oldF = mFlag[i];
        if (ev[i]) mFlag[i] = 1;
        else if (wrS && mArm[i] && ((wd >> bitIdx[i]) & 1) == 0) mFlag[i] = 0;
        if (ev[i]) mArm[i] = 0;
        else if (rdS && oldF) mArm[i] = 1;
        else if (wrS) mArm[i] = 0;
      end
      if (wrC) mCnt = wd;
      else if (cntEn) mCnt = (mCnt + 1) % 256;
      if (busWr && busAddr == 1) mCmpA = wd;
      if (busWr && busAddr == 2) mCmpB = wd;
      if (wrS) mSel = wd & 15;
    end
    #1;
    if (rst_n && !finished) begin
      chk("R8 timerOut vs model", timerOut, mOut);
      chk("R3 irqMatchA vs model", irqMatchA, mFlag[0]);
      chk("R3 irqMatchB vs model", irqMatchB, mFlag[1]);
      chk("R4 irqWrap vs model", irqWrap, mFlag[2]);
      chk("R1 busRdata vs model", busRdata, expRead(busAddr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdArm(input logic [1:0] a);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    @(negedge clk); busAddr = a; #1; v = busRdata;
  endtask

  task automatic run(input int n);
    @(negedge clk); cntEn = 1'b1;
    repeat (n) @(negedge clk);
    cntEn = 1'b0;
  endtask

  task automatic hitAt(input logic [7:0] v);
    wrReg(2'd0, v); run(1);
  endtask

  // ---------------- directed + random ----------------
  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    peek(2'd3, v); chk("R11 status after reset", v, 8'h10);
    peek(2'd0, v); chk("R11 counter after reset", v, 0);
    peek(2'd1, v); chk("R3 cmpA reset value", v, 8'hFF);
    chk("R11 timerOut after reset", timerOut, 0);

    // R5 / R7: writing ones never sets flags, reserved bit fixed
    wrReg(2'd3, 8'hFF);
    peek(2'd3, v); chk("R5 R7 write ones to status", v, 8'h1F);
    wrReg(2'd3, 8'h00);
    peek(2'd3, v); chk("R7 reserved bit after zero write", v, 8'h10);

    // R2 counter write suppresses match
    wrReg(2'd1, 8'd3);
    wrReg(2'd0, 8'd3);
    @(negedge clk); cntEn = 1'b1; busAddr = 2'd0; busWdata = 8'd10; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0; cntEn = 1'b0;
    chk("R2 no match on load cycle", irqMatchA, 0);
    peek(2'd0, v); chk("R2 counter loaded", v, 10);

    // R3 match sets flag, R12 pin equals bit
    wrReg(2'd0, 8'd2); run(2);
    chk("R3 match A flag set", irqMatchA, 1);
    peek(2'd3, v); chk("R12 status shows flag A", v, 8'h50);
    chk("R12 irqMatchA equals bit 6", irqMatchA, (v >> 6) & 1);

    // R5 clear protocol
    wrReg(2'd3, 8'h00);
    chk("R5 zero write without read keeps flag", irqMatchA, 1);
    rdArm(2'd3); wrReg(2'd3, 8'h00);
    chk("R5 read then zero clears", irqMatchA, 0);

    // R6 re-fire between arming read and clearing write
    hitAt(8'd3);
    chk("R6 flag set again", irqMatchA, 1);
    rdArm(2'd3);
    hitAt(8'd3);
    wrReg(2'd3, 8'h00);
    chk("R6 flag survives clear after re-fire", irqMatchA, 1);
    rdArm(2'd3); wrReg(2'd3, 8'h00);
    chk("R6 later clear works", irqMatchA, 0);

    // R4 wrap and R1 wraparound
    wrReg(2'd0, 8'hFE); run(2);
    chk("R4 wrap flag", irqWrap, 1);
    peek(2'd0, v); chk("R1 counter wrapped to zero", v, 0);
    chk("R12 irqMatchB from cmpB=FF", irqMatchB, 1);
    rdArm(2'd3); wrReg(2'd3, 8'h00);
    chk("R5 wrap flag cleared", irqWrap, 0);

    // R8 action codes on A and B
    wrReg(2'd3, 8'h02); hitAt(8'd3); chk("R8 A high", timerOut, 1);
    wrReg(2'd3, 8'h01); hitAt(8'd3); chk("R8 A low", timerOut, 0);
    wrReg(2'd3, 8'h03); hitAt(8'd3); chk("R8 A invert 1", timerOut, 1);
    hitAt(8'd3);                     chk("R8 A invert 2", timerOut, 0);
    wrReg(2'd2, 8'd9); wrReg(2'd3, 8'h08); hitAt(8'd9); chk("R8 B high", timerOut, 1);
    wrReg(2'd3, 8'h04); hitAt(8'd9); chk("R8 B low", timerOut, 0);

    // R9 priority with simultaneous matches
    wrReg(2'd1, 8'd7); wrReg(2'd2, 8'd7);
    wrReg(2'd3, 8'h09); hitAt(8'd7); chk("R9 B high over A low", timerOut, 1);
    wrReg(2'd3, 8'h0D); hitAt(8'd7); chk("R9 A low over B invert", timerOut, 0);
    wrReg(2'd3, 8'h0E); hitAt(8'd7); chk("R9 A high over B invert", timerOut, 1);
    wrReg(2'd3, 8'h06); hitAt(8'd7); chk("R9 B low over A high", timerOut, 0);
    wrReg(2'd3, 8'h0F); hitAt(8'd7); chk("R9 both invert once", timerOut, 1);

    // R10 disabled output
    wrReg(2'd3, 8'h00);
    @(negedge clk); chk("R10 output forced low", timerOut, 0);
    hitAt(8'd7); chk("R10 match ignored while disabled", timerOut, 0);

    // random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      busWr = 1'b0; busRd = 1'b0;
      cntEn = ($urandom_range(0, 9) < 7);
      busAddr = 2'($urandom_range(0, 3));
      busWdata = 8'($urandom_range(0, 255));
      if (r < 12) busWr = 1'b1;
      else if (r < 30) begin busAddr = 2'd3; busRd = 1'b1; end
      else if (r < 36) begin busAddr = 2'd3; busWdata = busWdata & 8'h1F; busWr = 1'b1; end
    end
    @(negedge clk); busWr = 1'b0; busRd = 1'b0; cntEn = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule